// File: doc/BRIEF.md
# Variable-Length Instruction Byte Parser

This block takes a stream of bytes belonging to a legacy 32-bit variable-length instruction format, one byte per cycle in which `byte_valid` is high, and splits it into instructions. Each instruction has up to four optional prefix bytes, then one opcode byte. Depending on the opcode, an addressing byte with mode, register and register/memory fields may follow. That can be followed by a scale/index/base byte, a displacement and an immediate. The parser finds where each instruction ends by applying these rules one byte at a time. When an instruction is complete it raises `done` for one cycle and presents every decoded field on registered outputs.

Only a small opcode subset is recognised. It covers register/memory arithmetic and moves, group-1 arithmetic with an immediate, single-byte register increments, direct-offset accumulator moves and the two relative jumps. Any other opcode byte ends the instruction at once with the illegal flag set. The byte after it starts a new instruction. An upstream fetch stage feeds the block, and a downstream decode or trace stage consumes the outputs while `done` is high.

Top module: `byte_insn_parser`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `done` is 0 and every field output is 0.
- R2: Before the opcode, the following bytes are taken as prefixes: F3, F2 and F0 set `lockrep` to 1, 2 and 3; 67 sets `addr16`; 66 sets `opsz16`. The segment bytes 26, 2E, 36, 3E, 64 and 65 set `seg_valid` and set `seg_code` to 0, 1, 2, 3, 4 and 5. If a class appears more than once, the last byte of that class wins.
- R3: When the opcode needs an addressing byte, `has_modrm` is 1 and that byte is split into `mod_f` (bits 7:6), `reg_f` (bits 5:3) and `rm_f` (bits 2:0). When `mod_f` is 11, there is neither a displacement nor a scale/index/base byte.
- R4: A scale/index/base byte follows the addressing byte only when mod is not 11 and rm is 100. That byte is reported as `scale_f` (7:6), `index_f` (5:3) and `base_f` (2:0), and `has_sib` is set to 1.
- R5: The displacement length is as follows. Mod 01 gives one byte and mod 10 gives four bytes. Mod 00 gives four bytes only when rm is 101, or when a scale/index/base byte is present with base 101; otherwise mod 00 gives none.
- R6: With the 67 prefix, every four-byte displacement becomes two bytes. This includes the direct offset of opcodes A1 and A3, which is four bytes otherwise.
- R7: Opcodes 80, 83 and EB carry a one-byte immediate. E9 carries a four-byte immediate. 81 carries four bytes, or two bytes when the 66 prefix is present. 03, 2B, 33, 3B, 8B, 38 and 39 carry none.
- R8: Displacement and immediate bytes are assembled little-endian and zero-extended into `disp` and `imm`. Unused fields read 0.
- R9: Opcodes 40 to 47 are complete in one byte and have no addressing byte.
- R10: Any opcode outside the subset finishes the instruction with `illegal` set to 1, the opcode reported, and a length of the prefix count plus one. The next byte is parsed as the start of a new instruction.
- R11: `done` is high for exactly the one cycle after the edge that accepts the final byte of an instruction. Bytes offered while `byte_valid` is low are ignored. `length` is the number of accepted bytes in the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | `byte_in` holds a stream byte this cycle |
| byte_in | input | 8 | Stream byte |
| done | output | 1 | One-cycle strobe: an instruction is complete |
| illegal | output | 1 | Opcode outside the subset |
| lockrep | output | 2 | 0 none, 1 F3, 2 F2, 3 F0 |
| addr16 | output | 1 | Address-size prefix seen |
| opsz16 | output | 1 | Operand-size prefix seen |
| seg_valid | output | 1 | Segment override present |
| seg_code | output | 3 | Override segment code |
| opcode | output | 8 | Opcode byte |
| has_modrm | output | 1 | Addressing byte present |
| mod_f | output | 2 | Mode field |
| reg_f | output | 3 | Register field |
| rm_f | output | 3 | Register/memory field |
| has_sib | output | 1 | Scale/index/base byte present |
| scale_f | output | 2 | Scale field |
| index_f | output | 3 | Index field |
| base_f | output | 3 | Base field |
| disp | output | 32 | Displacement, little-endian, zero-extended |
| imm | output | 32 | Immediate, little-endian, zero-extended |
| length | output | 4 | Total bytes in the instruction |

## Verification
Every result appears in the cycle after the rising edge that accepts the final byte of an instruction, and it is gone one cycle later. No result depends on how many bytes came before it or how long any gaps in the stream were. The bench drives bytes on the falling edge and samples on the falling edge that follows. It marks each final byte as it drives it, so in every sampled cycle it knows whether a strobe is due. Gaps with junk data and a low `byte_valid` are inserted into the stream, and the expected length counts only the accepted bytes.

// File: rtl/ipar_pkg.sv
package ipar_pkg;
  localparam int DISP_W = 32;
  localparam int IMM_W  = 32;
  localparam int LEN_W  = 4;
  localparam int CNT_W  = 3;
  localparam int IDX_W  = 2;

  typedef enum logic [2:0] {ST_PFX, ST_MODRM, ST_SIB, ST_DISP, ST_IMM} ipar_st_e;
  typedef enum logic [2:0] {PK_NONE, PK_LOCKREP, PK_ASIZE, PK_OSIZE, PK_SEG} pfx_kind_e;

  typedef struct packed {
    logic              illegal;
    logic [1:0]        rep;
    logic              a16;
    logic              o16;
    logic              segv;
    logic [2:0]        seg;
    logic [7:0]        opc;
    logic              hm;
    logic [7:0]        modrm;
    logic              hs;
    logic [7:0]        sib;
    logic [DISP_W-1:0] disp;
    logic [IMM_W-1:0]  imm;
    logic [LEN_W-1:0]  len;
  } insn_t;
endpackage

// File: rtl/ipar_prefix_dec.sv
module ipar_prefix_dec
  import ipar_pkg::*;
(
  input  logic [7:0] b,
  output pfx_kind_e  kind,
  output logic [1:0] rep_code,
  output logic [2:0] seg_code
);
  always_comb begin
    kind     = PK_NONE;
    rep_code = 2'd0;
    seg_code = 3'd0;
    case (b)
      8'hF3: begin kind = PK_LOCKREP; rep_code = 2'd1; end
      8'hF2: begin kind = PK_LOCKREP; rep_code = 2'd2; end
      8'hF0: begin kind = PK_LOCKREP; rep_code = 2'd3; end
      8'h67: kind = PK_ASIZE;
      8'h66: kind = PK_OSIZE;
      8'h26: begin kind = PK_SEG; seg_code = 3'd0; end
      8'h2E: begin kind = PK_SEG; seg_code = 3'd1; end
      8'h36: begin kind = PK_SEG; seg_code = 3'd2; end
      8'h3E: begin kind = PK_SEG; seg_code = 3'd3; end
      8'h64: begin kind = PK_SEG; seg_code = 3'd4; end
      8'h65: begin kind = PK_SEG; seg_code = 3'd5; end
      default: kind = PK_NONE;
    endcase
  end
endmodule

// File: rtl/ipar_op_dec.sv
module ipar_op_dec
  import ipar_pkg::*;
(
  input  logic [7:0]       opc,
  input  logic             a16,
  input  logic             o16,
  output logic             legal,
  output logic             needs_modrm,
  output logic [CNT_W-1:0] imm_len,
  output logic [CNT_W-1:0] disp_len
);
  logic [CNT_W-1:0] wide_addr;
  logic [CNT_W-1:0] wide_data;
  assign wide_addr = a16 ? CNT_W'(2) : CNT_W'(4);
  assign wide_data = o16 ? CNT_W'(2) : CNT_W'(4);

  always_comb begin
    legal       = 1'b0;
    needs_modrm = 1'b0;
    imm_len     = '0;
    disp_len    = '0;
    case (opc)
      8'h03, 8'h2B, 8'h33, 8'h3B, 8'h8B, 8'h38, 8'h39: begin
        legal = 1'b1; needs_modrm = 1'b1;
      end
      8'h80, 8'h83: begin
        legal = 1'b1; needs_modrm = 1'b1; imm_len = CNT_W'(1);
      end
      8'h81: begin
        legal = 1'b1; needs_modrm = 1'b1; imm_len = wide_data;
      end
      8'hA1, 8'hA3: begin
        legal = 1'b1; disp_len = wide_addr;
      end
      8'hEB: begin legal = 1'b1; imm_len = CNT_W'(1); end
      8'hE9: begin legal = 1'b1; imm_len = CNT_W'(4); end
      default: legal = (opc[7:3] == 5'b01000);
    endcase
  end
endmodule

// File: rtl/ipar_ea_dec.sv
module ipar_ea_dec
  import ipar_pkg::*;
(
  input  logic [7:0]       modrm,
  input  logic [2:0]       sib_base,
  input  logic             a16,
  output logic             need_sib,
  output logic [CNT_W-1:0] disp_len
);
  logic [1:0] md;
  logic [2:0] eff;
  logic [CNT_W-1:0] wide;
  assign md       = modrm[7:6];
  assign need_sib = (md != 2'b11) && (modrm[2:0] == 3'b100);
  assign eff      = need_sib ? sib_base : modrm[2:0];
  assign wide     = a16 ? CNT_W'(2) : CNT_W'(4);

  always_comb begin
    case (md)
      2'b00:   disp_len = (eff == 3'b101) ? wide : '0;
      2'b01:   disp_len = CNT_W'(1);
      2'b10:   disp_len = wide;
      default: disp_len = '0;
    endcase
  end
endmodule

// File: rtl/byte_insn_parser.sv
module byte_insn_parser
  import ipar_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [7:0]        byte_in,
  output logic              done,
  output logic              illegal,
  output logic [1:0]        lockrep,
  output logic              addr16,
  output logic              opsz16,
  output logic              seg_valid,
  output logic [2:0]        seg_code,
  output logic [7:0]        opcode,
  output logic              has_modrm,
  output logic [1:0]        mod_f,
  output logic [2:0]        reg_f,
  output logic [2:0]        rm_f,
  output logic              has_sib,
  output logic [1:0]        scale_f,
  output logic [2:0]        index_f,
  output logic [2:0]        base_f,
  output logic [DISP_W-1:0] disp,
  output logic [IMM_W-1:0]  imm,
  output logic [LEN_W-1:0]  length
);
  ipar_st_e         st, n_st;
  insn_t            w, n, q;
  logic [CNT_W-1:0] dlen, ilen, n_dlen, n_ilen;
  logic [IDX_W-1:0] idx, n_idx;
  logic             done_q, fin;

  pfx_kind_e        pk;
  logic [1:0]       pk_rep;
  logic [2:0]       pk_seg;
  logic             op_legal, op_modrm;
  logic [CNT_W-1:0] op_ilen, op_dlen;
  logic [7:0]       ea_modrm;
  logic             ea_sib;
  logic [CNT_W-1:0] ea_dlen;

  ipar_prefix_dec u_pfx (
    .b(byte_in), .kind(pk), .rep_code(pk_rep), .seg_code(pk_seg)
  );

  ipar_op_dec u_op (
    .opc(byte_in), .a16(w.a16), .o16(w.o16),
    .legal(op_legal), .needs_modrm(op_modrm),
    .imm_len(op_ilen), .disp_len(op_dlen)
  );

  assign ea_modrm = (st == ST_MODRM) ? byte_in : w.modrm;

  ipar_ea_dec u_ea (
    .modrm(ea_modrm), .sib_base(byte_in[2:0]), .a16(w.a16),
    .need_sib(ea_sib), .disp_len(ea_dlen)
  );

  logic             tail;
  logic [CNT_W-1:0] td, ti;

  always_comb begin
    n      = w;
    n_st   = st;
    n_dlen = dlen;
    n_ilen = ilen;
    n_idx  = idx;
    fin    = 1'b0;
    tail   = 1'b0;
    td     = '0;
    ti     = '0;
    if (byte_valid) begin
      n.len = w.len + LEN_W'(1);
      case (st)
        ST_PFX: begin
          if (pk != PK_NONE) begin
            case (pk)
              PK_LOCKREP: n.rep = pk_rep;
              PK_ASIZE:   n.a16 = 1'b1;
              PK_OSIZE:   n.o16 = 1'b1;
              default: begin n.segv = 1'b1; n.seg = pk_seg; end
            endcase
          end else begin
            n.opc = byte_in;
            if (!op_legal) begin
              n.illegal = 1'b1;
              fin       = 1'b1;
            end else if (op_modrm) begin
              n.hm   = 1'b1;
              n_ilen = op_ilen;
              n_st   = ST_MODRM;
            end else begin
              tail = 1'b1; td = op_dlen; ti = op_ilen;
            end
          end
        end
        ST_MODRM: begin
          n.modrm = byte_in;
          if (ea_sib) begin
            n.hs = 1'b1;
            n_st = ST_SIB;
          end else begin
            tail = 1'b1; td = ea_dlen; ti = ilen;
          end
        end
        ST_SIB: begin
          n.sib = byte_in;
          tail  = 1'b1; td = ea_dlen; ti = ilen;
        end
        ST_DISP: begin
          n.disp[{idx, 3'b000} +: 8] = byte_in;
          if (CNT_W'(idx) + CNT_W'(1) == dlen) begin
            n_idx = '0;
            if (ilen != '0) n_st = ST_IMM;
            else            fin  = 1'b1;
          end else begin
            n_idx = idx + IDX_W'(1);
          end
        end
        default: begin
          n.imm[{idx, 3'b000} +: 8] = byte_in;
          if (CNT_W'(idx) + CNT_W'(1) == ilen) fin   = 1'b1;
          else                                 n_idx = idx + IDX_W'(1);
        end
      endcase
      if (tail) begin
        n_dlen = td;
        n_ilen = ti;
        n_idx  = '0;
        if (td != '0)      n_st = ST_DISP;
        else if (ti != '0) n_st = ST_IMM;
        else               fin  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_PFX;
      w      <= '0;
      q      <= '0;
      done_q <= 1'b0;
      dlen   <= '0;
      ilen   <= '0;
      idx    <= '0;
    end else begin
      done_q <= fin;
      dlen   <= n_dlen;
      ilen   <= n_ilen;
      idx    <= n_idx;
      if (fin) begin
        q  <= n;
        w  <= '0;
        st <= ST_PFX;
      end else begin
        w  <= n;
        st <= n_st;
      end
    end
  end

  assign done      = done_q;
  assign illegal   = q.illegal;
  assign lockrep   = q.rep;
  assign addr16    = q.a16;
  assign opsz16    = q.o16;
  assign seg_valid = q.segv;
  assign seg_code  = q.seg;
  assign opcode    = q.opc;
  assign has_modrm = q.hm;
  assign mod_f     = q.modrm[7:6];
  assign reg_f     = q.modrm[5:3];
  assign rm_f      = q.modrm[2:0];
  assign has_sib   = q.hs;
  assign scale_f   = q.sib[7:6];
  assign index_f   = q.sib[5:3];
  assign base_f    = q.sib[2:0];
  assign disp      = q.disp;
  assign imm       = q.imm;
  assign length    = q.len;

  AST_DONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(byte_valid)); // R11
  AST_SIB_ONLY_MEM: assert property (@(posedge clk) disable iff (rst)
    (done && has_sib) |-> (has_modrm && mod_f != 2'b11 && rm_f == 3'b100)); // R4
  AST_REG_FORM_NO_DISP: assert property (@(posedge clk) disable iff (rst)
    (done && has_modrm && mod_f == 2'b11) |-> (disp == '0 && !has_sib)); // R3
  AST_ILLEGAL_BARE: assert property (@(posedge clk) disable iff (rst)
    (done && illegal) |-> (!has_modrm && disp == '0 && imm == '0)); // R10
  AST_SHORT_ADDR: assert property (@(posedge clk) disable iff (rst)
    (done && addr16) |-> (disp[DISP_W-1:16] == '0)); // R6
  AST_INC_ONE_BYTE: assert property (@(posedge clk) disable iff (rst)
    (done && opcode[7:3] == 5'b01000 && !illegal) |-> (!has_modrm && imm == '0)); // R9
endmodule

// File: tb/test_byte_insn_parser.sv
`timescale 1ns/1ps
module test_byte_insn_parser;
  localparam int EW = 103;
  localparam int WD = 5000;

  logic        clk = 1'b0;
  logic        rst;
  logic        byte_valid;
  logic [7:0]  byte_in;
  logic        done, illegal, addr16, opsz16, seg_valid, has_modrm, has_sib;
  logic [1:0]  lockrep, mod_f, scale_f;
  logic [2:0]  seg_code, reg_f, rm_f, index_f, base_f;
  logic [7:0]  opcode;
  logic [31:0] disp, imm;
  logic [3:0]  length;

  always #2 clk = ~clk;

  byte_insn_parser i_byte_insn_parser (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_in(byte_in),
    .done(done), .illegal(illegal), .lockrep(lockrep), .addr16(addr16),
    .opsz16(opsz16), .seg_valid(seg_valid), .seg_code(seg_code),
    .opcode(opcode), .has_modrm(has_modrm), .mod_f(mod_f), .reg_f(reg_f),
    .rm_f(rm_f), .has_sib(has_sib), .scale_f(scale_f), .index_f(index_f),
    .base_f(base_f), .disp(disp), .imm(imm), .length(length)
  );

  logic [8:0]    byte_q[$];
  logic [EW-1:0] exp_q[$];
  string         tag_q[$];
  int            pend = 0;
  int            total = 0;
  int            bad = 0;

  function automatic logic [EW-1:0] actual_vec();
    return {illegal, lockrep, addr16, opsz16, seg_valid, seg_code, opcode,
            has_modrm, mod_f, reg_f, rm_f, has_sib, scale_f, index_f, base_f,
            disp, imm, length};
  endfunction

  task automatic raw_pfx(input logic [7:0] b);
    byte_q.push_back({1'b0, b});
    pend++;
  endtask

  task automatic add_insn(input string tag, input logic [1:0] rep,
                          input logic a16, input logic o16, input logic segv,
                          input logic [2:0] seg, input logic [7:0] opc,
                          input logic hm, input logic [7:0] modrm,
                          input logic hs, input logic [7:0] sib,
                          input int dl, input logic [31:0] d,
                          input int il, input logic [31:0] im, input logic ill);
    logic [7:0] bytes[$];
    logic [7:0] sb;
    int n;
    bytes = {};
    if (rep == 2'd1) bytes.push_back(8'hF3);
    if (rep == 2'd2) bytes.push_back(8'hF2);
    if (rep == 2'd3) bytes.push_back(8'hF0);
    if (a16) bytes.push_back(8'h67);
    if (o16) bytes.push_back(8'h66);
    if (segv) begin
      case (seg)
        3'd0: sb = 8'h26;
        3'd1: sb = 8'h2E;
        3'd2: sb = 8'h36;
        3'd3: sb = 8'h3E;
        3'd4: sb = 8'h64;
        default: sb = 8'h65;
      endcase
      bytes.push_back(sb);
    end
    bytes.push_back(opc);
    if (hm) bytes.push_back(modrm);
    if (hs) bytes.push_back(sib);
    for (int k = 0; k < dl; k++) bytes.push_back(d[8*k +: 8]);
    for (int k = 0; k < il; k++) bytes.push_back(im[8*k +: 8]);
    n = bytes.size();
    for (int k = 0; k < n; k++) byte_q.push_back({(k == n - 1), bytes[k]});
    exp_q.push_back({ill, rep, a16, o16, segv, seg, opc, hm, modrm, hs, sib,
                     d, im, 4'(n + pend)});
    tag_q.push_back(tag);
    pend = 0;
  endtask

  initial begin
    logic          due;
    logic [8:0]    e;
    logic [EW-1:0] ev;
    string         tg;
    int            cyc, gcnt;
    due = 1'b0; cyc = 0; gcnt = 0;
    rst = 1'b1; byte_valid = 1'b0; byte_in = 8'h00;

    add_insn("R3", 0,0,0,0,0, 8'h03, 1, 8'hC8, 0, 0, 0, 0, 0, 0, 0);
    add_insn("R5", 0,0,0,0,0, 8'h03, 1, 8'h0D, 0, 0, 4, 32'h1B27D48C, 0, 0, 0);
    add_insn("R3", 0,0,0,0,0, 8'h8B, 1, 8'h13, 0, 0, 0, 0, 0, 0, 0);
    add_insn("R5", 0,0,0,0,0, 8'h33, 1, 8'h4A, 0, 0, 1, 32'h02, 0, 0, 0);
    add_insn("R4", 0,0,0,0,0, 8'h03, 1, 8'h04, 1, 8'h8B, 0, 0, 0, 0, 0);
    add_insn("R4", 0,0,0,0,0, 8'h2B, 1, 8'h8C, 1, 8'h7B, 4, 32'h12345678, 0, 0, 0);
    add_insn("R2", 0,0,1,1,0, 8'h3B, 1, 8'h84, 1, 8'h72, 4, 32'h00000200, 0, 0, 0);
    add_insn("R5", 0,0,0,0,0, 8'h8B, 1, 8'h04, 1, 8'h25, 4, 32'hCAFEF00D, 0, 0, 0);
    add_insn("R6", 0,1,0,0,0, 8'h8B, 1, 8'h05, 0, 0, 2, 32'h1234, 0, 0, 0);
    add_insn("R6", 0,1,0,0,0, 8'hA1, 0, 0, 0, 0, 2, 32'hBEEF, 0, 0, 0);
    add_insn("R6", 0,0,0,0,0, 8'hA3, 0, 0, 0, 0, 4, 32'h89ABCDEF, 0, 0, 0);
    add_insn("R7", 0,0,0,0,0, 8'h83, 1, 8'hC1, 0, 0, 0, 0, 1, 32'h05, 0);
    add_insn("R8", 0,0,0,0,0, 8'h80, 1, 8'h40, 0, 0, 1, 32'h10, 1, 32'h7F, 0);
    add_insn("R7", 0,0,0,0,0, 8'h81, 1, 8'hC0, 0, 0, 0, 0, 4, 32'hA1B2C3D4, 0);
    add_insn("R7", 0,0,1,0,0, 8'h81, 1, 8'hC0, 0, 0, 0, 0, 2, 32'h5566, 0);
    add_insn("R7", 0,0,0,0,0, 8'hEB, 0, 0, 0, 0, 0, 0, 1, 32'hF0, 0);
    add_insn("R8", 0,0,0,0,0, 8'hE9, 0, 0, 0, 0, 0, 0, 4, 32'h00010203, 0);
    add_insn("R9", 0,0,0,0,0, 8'h40, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    add_insn("R9", 0,0,0,0,0, 8'h47, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    add_insn("R10", 0,0,0,0,0, 8'h0F, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    add_insn("R10", 1,0,0,0,0, 8'hA5, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    add_insn("R10", 0,0,0,0,0, 8'h41, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    raw_pfx(8'hF2);
    add_insn("R2", 3,0,0,0,0, 8'h39, 1, 8'hD1, 0, 0, 0, 0, 0, 0, 0);
    raw_pfx(8'h2E);
    add_insn("R2", 2,0,0,1,5, 8'h8B, 1, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    add_insn("R2", 0,1,1,1,4, 8'h38, 1, 8'h45, 0, 0, 1, 32'h00, 0, 0, 0);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (done !== 1'b0 || actual_vec() !== '0) begin
      bad++;
      $display("FAIL R1 reset state: actual done=%b fields=%h expected 0", done, actual_vec());
    end

    while ((byte_q.size() > 0 || due) && cyc < WD) begin
      if (cyc > 0) @(negedge clk);
      cyc++;
      if (done !== due) begin
        total++; bad++;
        $display("FAIL R11 strobe timing: actual done=%b expected %b", done, due);
      end
      if (done === 1'b1) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R11 extra instruction: actual %h expected none", actual_vec());
        end else begin
          ev = exp_q.pop_front();
          tg = tag_q.pop_front();
          if (actual_vec() !== ev) begin
            bad++;
            $display("FAIL %s fields: actual %h expected %h", tg, actual_vec(), ev);
          end
        end
      end
      gcnt++;
      if (byte_q.size() > 0 && (gcnt % 7) != 4) begin
        e = byte_q.pop_front();
        byte_valid = 1'b1;
        byte_in = e[7:0];
        due = e[8];
      end else begin
        byte_valid = 1'b0;
        byte_in = 8'hF3;
        due = 1'b0;
      end
    end

    if (cyc >= WD) begin
      total++; bad++;
      $display("FAIL R11 watchdog: actual hung expected finish");
    end
    @(negedge clk);
    total++;
    if (done !== 1'b0 || exp_q.size() != 0) begin
      bad++;
      $display("FAIL R11 drain: actual done=%b pending=%0d expected 0 and 0", done, exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule